// File: doc/BRIEF.md
# Overcurrent Hiccup Retry Controller

This block sequences the shutdown and retry of a multiphase regulator after an overcurrent event. Two comparator flags feed it. One reports that the averaged phase current is above its fixed reference. The other reports that the current-monitor voltage is above its fixed threshold. Either flag alone trips the block. On a trip, every PWM phase is commanded to high impedance in the same clock cycle, so the drivers turn off both switches.

The phases then stay idle for a fixed number of switching cycles, counted on a single-cycle switching tick. At the end of that hold, if the controller is still enabled, the block asks the soft-start ramp to begin again. It keeps the request up until the ramp reports that it has started, and then returns to normal running. A fault that persists causes another trip, and the trip-hold-retry loop repeats with no limit on attempts. Dropping the enable at any point aborts the sequence and parks the block in an off state without a soft-start request.

Top module: `ochr_ctrl`

## Requirements
- R1: In the running state with enable high, `oc_avg_i` high on its own starts a shutdown.
- R2: In the running state with enable high, `oc_mon_i` high on its own starts a shutdown. Either flag alone is sufficient.
- R3: `hiz_o` goes high combinationally in the cycle where a flag is high in the running state, and it stays high through the hold that follows.
- R4: The hold ends on exactly the 4096th `sw_tick_i` pulse sampled after the hold begins. Clock cycles without a tick do not advance the hold. `hiz_o` stays high and `ss_req_o` stays low until that pulse.
- R5: In the cycle after the final hold tick, `ss_req_o` is 1 and `hiz_o` is 0. `ss_req_o` stays high until `ss_active_i` is sampled high. The block is then running, with `ss_req_o` at 0.
- R6: A fault still present when the block returns to running trips it again and starts a full new hold. This repeats on every retry.
- R7: Enable low in any state sends the block to off on the next edge, and `ss_req_o` is 0 from that same cycle. In the off state `hiz_o` is 0 and no request appears while enable stays low. Enable high in the off state returns the block to running on the next edge.
- R8: Both overcurrent flags are ignored during the hold and while the restart request is pending. In the request state `hiz_o` is 0 even when a flag is high.
- R9: While reset is asserted and after it, the block is off with `hiz_o` = 0 and `ss_req_o` = 0.
- R10: With both flags low in the running state, `hiz_o` stays 0 and the block stays running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Controller enabled (all enable conditions already qualified) |
| oc_avg_i | input | 1 | Averaged current above its fixed reference |
| oc_mon_i | input | 1 | Current-monitor voltage above its fixed threshold |
| sw_tick_i | input | 1 | One-cycle pulse per switching cycle |
| ss_active_i | input | 1 | Soft-start ramp has started |
| hiz_o | output | 1 | All PWM phases to high impedance |
| ss_req_o | output | 1 | Soft-start restart request |

## Verification
The assertions assume that every input is synchronous to `clk` and settled before each rising edge. They also assume that `sw_tick_i` is a single-cycle pulse and that `ss_active_i` answers a request rather than appearing on its own. The bench changes every input only on falling edges. It drives each tick high for one cycle and then low for one cycle, so no two ticks are adjacent. It controls `ss_active_i` directly, holding it low to test the request hold and high to test an immediate acknowledge.

// File: rtl/ochr_pkg.sv
package ochr_pkg;

  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_RUN     = 2'd1,
    ST_HOLD    = 2'd2,
    ST_RESTART = 2'd3
  } ochr_state_t;

  localparam int unsigned OCHR_N_SRC = 2;

endpackage

// File: rtl/ochr_trip_merge.sv
module ochr_trip_merge #(
  parameter int unsigned N_SRC = 2
) (
  input  logic [N_SRC-1:0] flag_i,
  output logic             trip_o
);

  // OR tree over all sources; any single source trips
  logic [N_SRC:0] acc;

  assign acc[0] = 1'b0;

  for (genvar g = 0; g < N_SRC; g++) begin : g_or
    assign acc[g+1] = acc[g] | flag_i[g];
  end

  assign trip_o = acc[N_SRC];

endmodule

// File: rtl/ochr_hold_timer.sv
module ochr_hold_timer #(
  parameter int unsigned HOLD_TICKS = 4096,
  localparam int unsigned CNT_W     = $clog2(HOLD_TICKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             step_i,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i | step_i;
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done_o = step_i & (cnt_q == LAST);
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/ochr_seq_fsm.sv
module ochr_seq_fsm
  import ochr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_i,
  input  logic        trip_i,
  input  logic        hold_done_i,
  input  logic        ss_active_i,
  output ochr_state_t state_o
);

  ochr_state_t state_q;
  ochr_state_t state_d;

  always_comb begin
    state_d = state_q;
    if (!en_i) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:     state_d = ST_RUN;
        ST_RUN:     if (trip_i)      state_d = ST_HOLD;
        ST_HOLD:    if (hold_done_i) state_d = ST_RESTART;
        ST_RESTART: if (ss_active_i) state_d = ST_RUN;
        default:    state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/ochr_ctrl.sv
module ochr_ctrl
  import ochr_pkg::*;
#(
  parameter int unsigned HOLD_TICKS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic oc_avg_i,
  input  logic oc_mon_i,
  input  logic sw_tick_i,
  input  logic ss_active_i,
  output logic hiz_o,
  output logic ss_req_o
);

  localparam int unsigned CNT_W = $clog2(HOLD_TICKS);

  logic              trip;
  logic              hold_done;
  logic              hold_step;
  logic              hold_clr;
  logic [CNT_W-1:0]  hold_cnt;
  ochr_state_t       state_q;

  ochr_trip_merge #(
    .N_SRC (OCHR_N_SRC)
  ) u_merge (
    .flag_i ({oc_mon_i, oc_avg_i}),
    .trip_o (trip)
  );

  // the counter only advances on ticks during the hold and is cleared elsewhere
  assign hold_step = (state_q == ST_HOLD) & sw_tick_i;
  assign hold_clr  = (state_q != ST_HOLD);

  ochr_hold_timer #(
    .HOLD_TICKS (HOLD_TICKS)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (hold_clr),
    .step_i (hold_step),
    .done_o (hold_done),
    .cnt_o  (hold_cnt)
  );

  ochr_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .trip_i      (trip),
    .hold_done_i (hold_done),
    .ss_active_i (ss_active_i),
    .state_o     (state_q)
  );

  // the same-cycle path from the trip flags keeps the shutdown within the detecting cycle
  assign hiz_o    = (state_q == ST_HOLD) | ((state_q == ST_RUN) & en_i & trip);
  assign ss_req_o = (state_q == ST_RESTART) & en_i;

endmodule

// File: rtl/ochr_chk.sv
module ochr_chk
  import ochr_pkg::*;
#(
  parameter int unsigned HOLD_TICKS = 4096,
  localparam int unsigned CNT_W     = $clog2(HOLD_TICKS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_i,
  input logic             oc_avg_i,
  input logic             oc_mon_i,
  input logic             sw_tick_i,
  input logic             ss_active_i,
  input logic             hiz_o,
  input logic             ss_req_o,
  input ochr_state_t      state_i,
  input logic [CNT_W-1:0] cnt_i
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_TICKS - 1);

  assert_trip_enters_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_RUN && en_i && (oc_avg_i || oc_mon_i)) |=> (state_i == ST_HOLD && hiz_o));

  assert_hold_count_still_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_HOLD && en_i && !sw_tick_i) |=> (cnt_i == $past(cnt_i)));

  assert_hold_ends_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_HOLD && en_i && sw_tick_i && cnt_i == LAST) |=> (ss_req_o || !en_i) && !hiz_o);

  assert_disable_parks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i) |=> (state_i == ST_OFF));

  assert_hold_ignores_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_HOLD && en_i && !(sw_tick_i && cnt_i == LAST)) |=> (state_i == ST_HOLD));

  assert_request_waits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_RESTART && en_i && !ss_active_i) |=> (state_i == ST_RESTART));

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(hiz_o && ss_req_o));

endmodule

bind ochr_ctrl ochr_chk #(
  .HOLD_TICKS (HOLD_TICKS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en_i        (en_i),
  .oc_avg_i    (oc_avg_i),
  .oc_mon_i    (oc_mon_i),
  .sw_tick_i   (sw_tick_i),
  .ss_active_i (ss_active_i),
  .hiz_o       (hiz_o),
  .ss_req_o    (ss_req_o),
  .state_i     (state_q),
  .cnt_i       (hold_cnt)
);

// File: tb/ochr_ctrl_tb.sv
module ochr_ctrl_tb;

  localparam int unsigned HOLD = 4096;

  logic clk;
  logic rst_n;
  logic en;
  logic oc_avg;
  logic oc_mon;
  logic tick;
  logic ss_act;
  logic hiz;
  logic ss_req;

  int n_chk;
  int n_fail;

  ochr_ctrl #(.HOLD_TICKS(HOLD)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en),
    .oc_avg_i    (oc_avg),
    .oc_mon_i    (oc_mon),
    .sw_tick_i   (tick),
    .ss_active_i (ss_act),
    .hiz_o       (hiz),
    .ss_req_o    (ss_req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // vector: {en, oc_avg, oc_mon, hiz now, hiz after edge}
  localparam int NV = 8;
  localparam logic [4:0] VEC [NV] = '{
    5'b1_0_0_0_0, 5'b1_1_0_1_1, 5'b1_0_1_1_1, 5'b1_1_1_1_1,
    5'b0_0_0_0_0, 5'b0_1_0_0_0, 5'b0_0_1_0_0, 5'b0_1_1_0_0
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en = 1'b1; oc_avg = 1'b0; oc_mon = 1'b0; tick = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; en = 1'b1; oc_avg = 1'b0; oc_mon = 1'b0; tick = 1'b0; ss_act = 1'b1;
    #1;
    chk("R9", "hiz in reset", hiz, 1'b0);
    chk("R9", "req in reset", ss_req, 1'b0);
    repeat (3) @(negedge clk);
    chk("R9", "hiz in reset later", hiz, 1'b0);
    rst_n = 1'b1;
    chk("R9", "req after reset", ss_req, 1'b0);

    // table walk: same-cycle and next-cycle shutdown command
    for (int v = 0; v < NV; v++) begin
      string tag;
      do_reset();
      {en, oc_avg, oc_mon} = VEC[v][4:2];
      tag = !en ? "R7" : (oc_avg && oc_mon) ? "R3" : oc_avg ? "R1" : oc_mon ? "R2" : "R10";
      #1;
      chk(tag, "hiz same cycle", hiz, VEC[v][1]);
      @(negedge clk);
      oc_avg = 1'b0; oc_mon = 1'b0;
      #1;
      chk(tag, "hiz after edge", hiz, VEC[v][0]);
      chk(tag, "req after edge", ss_req, 1'b0);
    end

    // exact hold length, flags ignored, repeated retry, clean recovery
    do_reset();
    ss_act = 1'b1;
    oc_mon = 1'b1;
    @(negedge clk);
    oc_avg = 1'b1;
    tick_n(HOLD - 1);
    chk("R4", "hiz before last tick", hiz, 1'b1);
    chk("R4", "req before last tick", ss_req, 1'b0);
    tick_n(1);
    chk("R5", "req after last tick", ss_req, 1'b1);
    chk("R8", "hiz in restart with flags", hiz, 1'b0);
    @(negedge clk);
    chk("R6", "hiz on retry into fault", hiz, 1'b1);
    tick_n(HOLD);
    chk("R6", "req on second retry", ss_req, 1'b1);
    oc_avg = 1'b0; oc_mon = 1'b0;
    @(negedge clk);
    chk("R10", "hiz after fault clears", hiz, 1'b0);
    chk("R10", "req after acknowledge", ss_req, 1'b0);
    repeat (5) @(negedge clk);
    chk("R10", "hiz while running clean", hiz, 1'b0);
    oc_avg = 1'b1;
    #1;
    chk("R1", "still running after recovery", hiz, 1'b1);
    oc_avg = 1'b0;

    // request held until the ramp reports start
    do_reset();
    ss_act = 1'b0;
    oc_avg = 1'b1;
    @(negedge clk);
    oc_avg = 1'b0;
    tick_n(HOLD);
    chk("R5", "req raised", ss_req, 1'b1);
    repeat (3) @(negedge clk);
    chk("R5", "req held without ack", ss_req, 1'b1);
    ss_act = 1'b1;
    @(negedge clk);
    chk("R5", "req drops after ack", ss_req, 1'b0);
    chk("R5", "running after ack", hiz, 1'b0);

    // disable during hold
    do_reset();
    ss_act = 1'b0;
    oc_mon = 1'b1;
    @(negedge clk);
    oc_mon = 1'b0;
    tick_n(100);
    en = 1'b0;
    @(negedge clk);
    chk("R7", "hiz after abort", hiz, 1'b0);
    chk("R7", "req after abort", ss_req, 1'b0);
    tick_n(HOLD);
    chk("R7", "no req while disabled", ss_req, 1'b0);
    en = 1'b1;
    @(negedge clk);
    oc_mon = 1'b1;
    #1;
    chk("R7", "running after re-enable", hiz, 1'b1);

    // disable while the request is pending
    @(negedge clk);
    oc_mon = 1'b0;
    tick_n(HOLD);
    chk("R5", "req pending", ss_req, 1'b1);
    en = 1'b0;
    #1;
    chk("R7", "req gated same cycle", ss_req, 1'b0);
    @(negedge clk);
    chk("R7", "req off after edge", ss_req, 1'b0);
    chk("R7", "hiz off after edge", hiz, 1'b0);

    finish_run();
  end

endmodule